// File: doc/BRIEF.md
# Refresh Interval Timer

This block paces memory refresh for a bus controller. A free-running prescaler divides the bus clock, and a selectable tap drives an 8-bit interval counter. When the counter reaches the value in a compare register, the counter returns to zero and a sticky match flag goes high. Each of these points marks one refresh that is due. Every match also adds one to a refresh tally. When the tally climbs past a limit of 512 or 1024, a sticky overflow flag is raised. Both flags are brought out as level outputs.

Software reaches four 16-bit registers through a simple bus with a one-cycle select. The registers are control/status, interval count, compare and tally. A write to the interval count only lands when it is a full 16-bit access whose upper byte carries a fixed key. This guards the counter against stray writes. Power-on reset clears everything. Manual reset clears the flags and the tally, but the counter, compare, control fields and prescaler are left alone, so counting carries on through it. Standby freezes the prescaler and the counter in place.

Register select on `bus_addr`: 0 control/status, 1 interval count, 2 compare, 3 tally. Control/status bits: [2:0] clock select, [3] limit select, [6] overflow flag, [7] match flag. All other bits read zero.

Top module: `refresh_timer`

## Requirements
- R1: After power-on reset all four registers read 0 and both flag outputs are 0, including when the counter was nonzero before the reset.
- R2: A write to the count register changes the counter only when `bus_word` is 1 and `bus_wdata[15:8]` is 0xA5, in which case the counter takes `bus_wdata[7:0]`; every other count write leaves it unchanged, and a keyed write beats a tick in the same cycle.
- R3: The count register reads with bits 15:8 always zero and the counter value in bits 7:0.
- R4: On a tick where the counter equals the compare value, the counter becomes 0 and the match flag is set; on any other tick it increments by one.
- R5: Clock-select code 0 stops counting; codes 1 to 7 give one tick every 4, 16, 64, 256, 1024, 2048 and 4096 bus cycles from a prescaler that runs from power-on reset.
- R6: Each compare match adds one to the tally; any write to the tally register clears it regardless of data, and the clear wins over a match in the same cycle.
- R7: Limit select 0 gives a limit of 1024 and 1 gives 512; the overflow flag is set by the match that takes the tally from the limit to the limit plus one.
- R8: Writing 0 to a flag bit of the control/status register clears it only if a control/status read returned that flag as 1 since the last control/status write; writing 1, or 0 without such a read, leaves it; a flag event in the same cycle as a clear keeps the flag at 1.
- R9: While `mrst_n` is low (sampled on the clock), the flags, the tally and the read arming are held at 0 and bus writes are ignored, while the counter, compare, clock select, limit select and prescaler keep their values and counting continues.
- R10: While `standby` is high the prescaler and counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| standby | input | 1 | Freezes prescaler and counter while high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_word | input | 1 | 1 when the access is a full 16-bit word |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while a read is selected, else 0 |
| match_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky tally overflow flag |

## Verification
A software clear of the match flag and a fresh compare match can land on the same clock edge. With compare 0 and the fastest divisor, a match happens exactly every four cycles. The bench waits for the flag to rise, arms it with a status read, and times its clearing write to be sampled on the edge of the next match. The flag must still read 1 afterwards. A second clear, placed two cycles off the match, must drop the flag, and the following match must raise it again.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

    localparam int DATA_W  = 16;
    localparam int CKS_W   = 3;
    localparam int NUM_CKS = 1 << CKS_W;

    // register select on the bus
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CMP   = 2'd2,
        REG_TALLY = 2'd3
    } reg_sel_e;

    // control/status bit positions
    localparam int BIT_LMS   = 3;
    localparam int BIT_OFLAG = 6;
    localparam int BIT_MFLAG = 7;

    // log2 of the prescaler divisor for each clock-select code, 0 = stopped
    function automatic int cks_shift(input int code);
        if (code == 0)      return 0;
        else if (code <= 5) return 2 * code;
        else                return code + 5;
    endfunction

endpackage

// File: rtl/rfi_prescaler.sv
module rfi_prescaler
    import rfi_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] mask_tab [NUM_CKS];

    generate
        for (genvar g = 0; g < NUM_CKS; g++) begin : g_tap
            localparam int SH = cks_shift(g);
            if (SH == 0) begin : g_off
                assign mask_tab[g] = '0;
            end else if (SH >= PRE_W) begin : g_full
                assign mask_tab[g] = '1;
            end else begin : g_part
                assign mask_tab[g] = PRE_W'((1 << SH) - 1);
            end
        end
    endgenerate

    logic [PRE_W-1:0] sel_mask;
    assign sel_mask = mask_tab[cks];
    assign tick     = run && (cks != '0) && ((st_q.pre & sel_mask) == sel_mask);

    always_comb begin
        st_d = st_q;
        if (run) st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: prescaler frozen while not running
    p_pre_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        !run |=> $stable(st_q.pre));

endmodule

// File: rtl/rfi_interval.sv
module rfi_interval #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             load_cnt,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_cmp,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic             match
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
    } ivl_st_t;

    ivl_st_t st_d, st_q;

    assign match = tick && !load_cnt && (st_q.cnt == st_q.cmp);
    assign cnt   = st_q.cnt;
    assign cmp   = st_q.cmp;

    always_comb begin
        st_d = st_q;
        if (load_cnt) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == st_q.cmp) st_d.cnt = '0;
            else                      st_d.cnt = st_q.cnt + 1'b1;
        end
        if (load_cmp) st_d.cmp = cmp_val;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!por_n)
        load_cnt |=> (st_q.cnt == $past(load_val)));

    p_clear_on_match_r4: assert property (@(posedge clk) disable iff (!por_n)
        match |=> (st_q.cnt == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (!por_n)
        (tick && !load_cnt && !match) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (!tick && !load_cnt) |=> $stable(st_q.cnt));

endmodule

// File: rtl/rfi_tally.sv
module rfi_tally #(
    parameter int TALLY_W = 11
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               mrst_n,
    input  logic               inc,
    input  logic               clr,
    input  logic               lim_sel,
    output logic [TALLY_W-1:0] tally,
    output logic               ovf_evt
);

    localparam logic [TALLY_W-1:0] LIM_WIDE   = TALLY_W'(1024);
    localparam logic [TALLY_W-1:0] LIM_NARROW = TALLY_W'(512);

    typedef struct packed {
        logic [TALLY_W-1:0] tally;
    } tly_st_t;

    tly_st_t st_d, st_q;
    logic [TALLY_W-1:0] limit;

    assign limit   = lim_sel ? LIM_NARROW : LIM_WIDE;
    assign ovf_evt = mrst_n && inc && !clr && (st_q.tally == limit);
    assign tally   = st_q.tally;

    always_comb begin
        st_d = st_q;
        if (!mrst_n || clr) st_d.tally = '0;
        else if (inc)       st_d.tally = st_q.tally + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_tally_step_r6: assert property (@(posedge clk) disable iff (!por_n)
        (mrst_n && inc && !clr) |=> (st_q.tally == TALLY_W'($past(st_q.tally) + 1'b1)));

    p_tally_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
        (clr || !mrst_n) |=> (st_q.tally == '0));

    p_ovf_at_limit_r7: assert property (@(posedge clk) disable iff (!por_n)
        ovf_evt |=> (st_q.tally == TALLY_W'($past(limit) + 1'b1)));

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
    import rfi_pkg::*;
#(
    parameter int         CNT_W   = 8,
    parameter int         TALLY_W = 11,
    parameter int         PRE_W   = 12,
    parameter logic [7:0] KEY     = 8'hA5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              standby,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              match_flag,
    output logic              ovf_flag
);

    typedef struct packed {
        logic [CKS_W-1:0] cks;
        logic             lms;
        logic             m_flag;
        logic             o_flag;
        logic             m_arm;
        logic             o_arm;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    reg_sel_e           rsel;
    logic               wr_en, ctrl_wr, ctrl_rd, key_ok, keyed_wr, cmp_wr, tally_wr;
    logic               tick, match_evt, ovf_evt;
    logic [CNT_W-1:0]   cnt, cmp;
    logic [TALLY_W-1:0] tally;

    assign rsel     = reg_sel_e'(bus_addr);
    assign wr_en    = bus_sel && bus_wr && mrst_n;
    assign ctrl_wr  = wr_en && (rsel == REG_CTRL);
    assign ctrl_rd  = bus_sel && !bus_wr && (rsel == REG_CTRL);
    assign key_ok   = bus_word && (bus_wdata[15:8] == KEY);
    assign keyed_wr = wr_en && (rsel == REG_COUNT) && key_ok;
    assign cmp_wr   = wr_en && (rsel == REG_CMP);
    assign tally_wr = wr_en && (rsel == REG_TALLY);

    rfi_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .por_n (por_n),
        .run   (!standby),
        .cks   (st_q.cks),
        .tick  (tick)
    );

    rfi_interval #(.CNT_W(CNT_W)) u_ivl (
        .clk      (clk),
        .por_n    (por_n),
        .tick     (tick),
        .load_cnt (keyed_wr),
        .load_val (bus_wdata[CNT_W-1:0]),
        .load_cmp (cmp_wr),
        .cmp_val  (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .cmp      (cmp),
        .match    (match_evt)
    );

    rfi_tally #(.TALLY_W(TALLY_W)) u_tly (
        .clk     (clk),
        .por_n   (por_n),
        .mrst_n  (mrst_n),
        .inc     (match_evt),
        .clr     (tally_wr),
        .lim_sel (st_q.lms),
        .tally   (tally),
        .ovf_evt (ovf_evt)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.cks   = bus_wdata[CKS_W-1:0];
            st_d.lms   = bus_wdata[BIT_LMS];
            st_d.m_arm = 1'b0;
            st_d.o_arm = 1'b0;
            if (st_q.m_arm && !bus_wdata[BIT_MFLAG]) st_d.m_flag = 1'b0;
            if (st_q.o_arm && !bus_wdata[BIT_OFLAG]) st_d.o_flag = 1'b0;
        end
        if (ctrl_rd) begin
            st_d.m_arm = st_q.m_arm | st_q.m_flag;
            st_d.o_arm = st_q.o_arm | st_q.o_flag;
        end
        // a new event outranks a software clear in the same cycle
        if (match_evt) st_d.m_flag = 1'b1;
        if (ovf_evt)   st_d.o_flag = 1'b1;
        if (!mrst_n) begin
            st_d.m_flag = 1'b0;
            st_d.o_flag = 1'b0;
            st_d.m_arm  = 1'b0;
            st_d.o_arm  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (rsel)
                REG_CTRL: begin
                    bus_rdata[CKS_W-1:0] = st_q.cks;
                    bus_rdata[BIT_LMS]   = st_q.lms;
                    bus_rdata[BIT_OFLAG] = st_q.o_flag;
                    bus_rdata[BIT_MFLAG] = st_q.m_flag;
                end
                REG_COUNT: bus_rdata = DATA_W'(cnt);
                REG_CMP:   bus_rdata = DATA_W'(cmp);
                REG_TALLY: bus_rdata = DATA_W'(tally);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign match_flag = st_q.m_flag;
    assign ovf_flag   = st_q.o_flag;

    p_unkeyed_ignored_r2: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && bus_wr && (rsel == REG_COUNT) && !key_ok && !tick) |=> $stable(cnt));

    p_stopped_r5: assert property (@(posedge clk) disable iff (!por_n)
        ((st_q.cks == '0) && !keyed_wr) |=> $stable(cnt));

    p_standby_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (standby && !keyed_wr) |=> $stable(cnt));

    p_match_sets_r4: assert property (@(posedge clk) disable iff (!por_n)
        (mrst_n && match_evt) |=> match_flag);

    p_ovf_sets_r7: assert property (@(posedge clk) disable iff (!por_n)
        (mrst_n && ovf_evt) |=> ovf_flag);

    p_unarmed_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
        (mrst_n && match_flag && !st_q.m_arm) |=> match_flag);

    p_mrst_clear_r9: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> (!match_flag && !ovf_flag && (tally == '0)));

    p_mrst_keep_cmp_r9: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> ($stable(cmp) && $stable(st_q.cks) && $stable(st_q.lms)));

endmodule

// File: tb/refresh_timer_tb.sv
module refresh_timer_tb;
    import rfi_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        por_n, mrst_n, standby;
    logic        bus_sel, bus_wr, bus_word;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        match_flag, ovf_flag;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;
    logic [2:0] cur_cks = '0;
    logic       cur_lms = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_timer u_dut (
        .clk        (clk),
        .por_n      (por_n),
        .mrst_n     (mrst_n),
        .standby    (standby),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_word   (bus_word),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .match_flag (match_flag),
        .ovf_flag   (ovf_flag)
    );

    function automatic logic [7:0] exp_keyed(input logic [7:0] prev, input logic [7:0] up,
                                             input logic [7:0] lo, input logic word);
        return (word && up == 8'hA5) ? lo : prev;
    endfunction

    function automatic int div_of(input int code);
        int tab [8] = '{0, 4, 16, 64, 256, 1024, 2048, 4096};
        return tab[code];
    endfunction

    function automatic logic [15:0] exp_ctrl(input logic [2:0] c, input logic l,
                                             input logic m, input logic o);
        return {8'h00, m, o, 2'b00, l, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic peek(input reg_sel_e a, output logic [15:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_read(input reg_sel_e a, output logic [15:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_write(input reg_sel_e a, input logic [15:0] d, input logic w);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_word = w;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // flag bits written as 1 so a plain control write never clears a flag
    task automatic set_ctrl(input logic [2:0] c, input logic l);
        cur_cks = c; cur_lms = l;
        do_write(REG_CTRL, exp_ctrl(c, l, 1'b1, 1'b1), 1'b1);
    endtask

    task automatic clear_flags();
        logic [15:0] v;
        do_read(REG_CTRL, v);
        do_write(REG_CTRL, exp_ctrl(cur_cks, cur_lms, 1'b0, 1'b0), 1'b1);
    endtask

    task automatic measure(input int code);
        logic [15:0] v;
        logic [7:0]  prev;
        int first, gap, d;
        d = div_of(code);
        set_ctrl(3'd0, cur_lms);
        do_write(REG_CMP, 16'h00FF, 1'b1);
        do_write(REG_COUNT, 16'hA500, 1'b1);
        set_ctrl(3'(code), cur_lms);
        prev = 8'h00; first = -1; gap = -1;
        for (int i = 0; i < 3 * d + 20 && gap < 0; i++) begin
            @(negedge clk);
            peek(REG_COUNT, v);
            if (v[7:0] != prev) begin
                if (first < 0) first = i;
                else           gap = i - first;
                prev = v[7:0];
            end
        end
        chk($sformatf("R5 divisor code %0d", code), gap, d);
    endtask

    task automatic await_ovf(input int limit);
        logic [15:0] v;
        int prev_t, seen;
        do_write(REG_TALLY, 16'h0000, 1'b1);
        prev_t = 0; seen = 0;
        for (int i = 0; i < 4 * limit + 100 && !seen; i++) begin
            @(negedge clk);
            peek(REG_TALLY, v);
            if (ovf_flag) begin
                seen = 1;
                chk("R7 tally at overflow", v, limit + 1);
                chk("R7 tally before overflow", prev_t, limit);
            end
            prev_t = int'(v);
        end
        chk("R7 overflow seen", seen, 1);
    endtask

    initial begin
        logic [15:0] v, v2, t0;
        logic [7:0]  exp_cnt;
        logic [7:0]  pc, pt;
        int          wraps;

        void'($urandom(32'd20240611));
        por_n = 1'b0; mrst_n = 1'b1; standby = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_word = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(REG_CTRL, v);  chk("R1 ctrl", v, 16'h0000);
        peek(REG_COUNT, v); chk("R1 count", v, 16'h0000);
        peek(REG_CMP, v);   chk("R1 compare", v, 16'h0000);
        peek(REG_TALLY, v); chk("R1 tally", v, 16'h0000);
        chk("R1 flags", {match_flag, ovf_flag}, 2'b00);

        // R2/R3 random keyed and unkeyed writes, counter stopped
        exp_cnt = 8'h00;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] up, lo;
            logic       w;
            up = ($urandom % 3 == 0) ? 8'($urandom) : 8'hA5;
            w  = ($urandom % 4) != 0;
            lo = 8'($urandom);
            do_write(REG_COUNT, {up, lo}, w);
            exp_cnt = exp_keyed(exp_cnt, up, lo, w);
            peek(REG_COUNT, v);
            chk("R2 keyed write", v[7:0], exp_cnt);
            chk("R3 upper byte zero", v[15:8], 8'h00);
        end
        do_write(REG_COUNT, 16'h5A33, 1'b1);
        peek(REG_COUNT, v); chk("R2 wrong key", v[7:0], exp_cnt);
        do_write(REG_COUNT, 16'hA533, 1'b0);
        peek(REG_COUNT, v); chk("R2 byte access", v[7:0], exp_cnt);

        // R5 stop code, then every divisor
        peek(REG_COUNT, v);
        repeat (300) @(negedge clk);
        peek(REG_COUNT, v2); chk("R5 stopped", v2, v);
        for (int c = 1; c < 8; c++) measure(c);

        // R4/R6 wrap at compare with tally stepping
        set_ctrl(3'd0, 1'b0);
        do_write(REG_CMP, 16'h0002, 1'b1);
        do_write(REG_COUNT, 16'hA500, 1'b1);
        do_write(REG_TALLY, 16'hFFFF, 1'b1);
        peek(REG_TALLY, v); chk("R6 tally write clears", v, 16'h0000);
        clear_flags();
        chk("R8 armed clear", match_flag, 1'b0);
        set_ctrl(3'd1, 1'b0);
        pc = 8'h00; pt = 8'h00; wraps = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            peek(REG_COUNT, v);
            peek(REG_TALLY, t0);
            if (v[7:0] != pc) begin
                if (pc == 8'h02) begin
                    chk("R4 clear at compare", v[7:0], 8'h00);
                    chk("R6 tally step", t0[7:0], 8'(pt + 1));
                    chk("R4 match flag", match_flag, 1'b1);
                    wraps++;
                end else begin
                    chk("R4 increment", v[7:0], 8'(pc + 1));
                    chk("R6 tally still", t0[7:0], pt);
                end
            end
            pc = v[7:0]; pt = t0[7:0];
        end
        chk("R4 wraps seen", wraps, 6);

        // R7 overflow at both limits, R8 clear rules
        do_write(REG_CMP, 16'h0000, 1'b1);
        set_ctrl(3'd1, 1'b1);
        clear_flags();
        await_ovf(512);
        clear_flags();
        chk("R8 ovf cleared", ovf_flag, 1'b0);
        set_ctrl(3'd1, 1'b0);
        await_ovf(1024);
        do_write(REG_CTRL, exp_ctrl(cur_cks, cur_lms, 1'b0, 1'b0), 1'b1);
        chk("R8 unarmed clear ignored", ovf_flag, 1'b1);
        set_ctrl(3'd0, 1'b0);
        clear_flags();
        chk("R8 clear both", {match_flag, ovf_flag}, 2'b00);
        set_ctrl(3'd0, 1'b0);
        peek(REG_CTRL, v); chk("R8 writing 1 no set", v, exp_ctrl(3'd0, 1'b0, 1'b0, 1'b0));

        // R8 clear and match on the same edge
        set_ctrl(3'd1, 1'b0);
        for (int a = 0; a < 8; a++) begin
            clear_flags();
            if (!match_flag) break;
        end
        for (int i = 0; i < 20 && !match_flag; i++) @(negedge clk);
        do_read(REG_CTRL, v);
        @(negedge clk);
        @(negedge clk);
        do_write(REG_CTRL, exp_ctrl(cur_cks, cur_lms, 1'b0, 1'b0), 1'b1);
        chk("R8 event wins over clear", match_flag, 1'b1);
        do_read(REG_CTRL, v);
        do_write(REG_CTRL, exp_ctrl(cur_cks, cur_lms, 1'b0, 1'b0), 1'b1);
        chk("R8 clear off the match", match_flag, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R4 next match sets", match_flag, 1'b1);

        // R9 manual reset: retention with the counter stopped
        set_ctrl(3'd0, 1'b1);
        do_write(REG_CMP, 16'h00F0, 1'b1);
        do_write(REG_COUNT, 16'hA55C, 1'b1);
        mrst_n = 1'b0;
        do_write(REG_CMP, 16'h0011, 1'b1);
        mrst_n = 1'b1;
        peek(REG_COUNT, v); chk("R9 count kept", v, 16'h005C);
        peek(REG_CMP, v);   chk("R9 compare kept, write ignored", v, 16'h00F0);
        peek(REG_CTRL, v);  chk("R9 ctrl fields kept, flags cleared", v, exp_ctrl(3'd0, 1'b1, 1'b0, 1'b0));
        peek(REG_TALLY, v); chk("R9 tally cleared", v, 16'h0000);

        // R9 counting continues through manual reset
        set_ctrl(3'd1, 1'b1);
        peek(REG_COUNT, v);
        mrst_n = 1'b0;
        repeat (40) @(negedge clk);
        peek(REG_COUNT, v2);
        mrst_n = 1'b1;
        chk("R9 counting continues", v2, 16'(v + 10));

        // R10 standby holds, then resumes
        peek(REG_COUNT, v);
        standby = 1'b1;
        repeat (100) @(negedge clk);
        peek(REG_COUNT, v2); chk("R10 hold in standby", v2, v);
        standby = 1'b0;
        repeat (40) @(negedge clk);
        peek(REG_COUNT, v2); chk("R10 resumes after standby", v2, 16'(v + 10));

        // R1 power-on reset clears a nonzero counter
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        peek(REG_COUNT, v); chk("R1 count after power-on", v, 16'h0000);
        peek(REG_CTRL, v);  chk("R1 ctrl after power-on", v, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: requirement all, actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule